// File: doc/BRIEF.md
# Byte-Sequenced Host Data Register Port

This block lets an 8-bit host bus reach a 16-bit data register that a signal processor core loads and drains. A width select picks how the host accesses the register. In wide mode one 16-bit transfer takes two byte accesses, and the high byte always comes first. In narrow mode one byte access completes the transfer. A pending-half flag records which byte the next wide access will touch. A transfer-request flag is raised when the core loads the register, and it drops once the host has finished its transfer.

The core side loads the register in one cycle. That load sets the request flag and sends the byte sequence back to the high half. A core load has priority over any host strobe in the same cycle. Host strobes are synchronous: the register and both flags change on the clock edge at which a strobe is sampled high. The read byte is a combinational function of the state before that edge.

Top module: `host_dr_port`

## Requirements
- R1: Synchronous reset clears the register to 0x0000 and clears both the pending-half flag and the request flag. The request flag is not set by reset.
- R2: A core load writes the 16-bit core word into the register on the next edge, sets the request flag and clears the pending-half flag.
- R3: When a core load and a host strobe are sampled in the same cycle, only the core load takes effect.
- R4: Wide-mode read with the pending-half flag at 0: the read byte is register bits 15:8. After the edge the flag is 1, and the register and request flag are unchanged.
- R5: Wide-mode read with the pending-half flag at 1: the read byte is register bits 7:0. After the edge both flags are 0 and the register is unchanged.
- R6: Wide-mode write with the pending-half flag at 0: the byte replaces bits 15:8, bits 7:0 are kept, the pending-half flag becomes 1 and the request flag is unchanged.
- R7: Wide-mode write with the pending-half flag at 1: the byte replaces bits 7:0, bits 15:8 are kept, and both flags become 0.
- R8: Narrow-mode read: the read byte is bits 7:0. After the edge the request flag is 0, and the register and pending-half flag are unchanged.
- R9: Narrow-mode write: the register becomes {0x00, byte}, the request flag becomes 0 and the pending-half flag is unchanged.
- R10: A host read and a host write sampled together, with no core load, act as the write alone.
- R11: With no strobe and no core load, the register and both flags hold their values.
- R12: The read-data output always shows the byte a read would return from the current state: bits 15:8 in wide mode with the flag at 0, and bits 7:0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 = two-byte transfers, 0 = one-byte transfers |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte presented to the host |
| core_load | input | 1 | Core-side register load |
| core_data | input | 16 | Word loaded by the core |
| dr_q | output | 16 | Current register contents |
| req_pending | output | 1 | Transfer-request flag |
| half_sel | output | 1 | Pending-half flag (1 = low byte next) |

## Verification
The bench targets four weak spots. A design with swapped byte order would return or overwrite the low half first, and a wrong masking step would clear the kept half of a wide write. A design that drops the request flag after the first wide byte would hand control back to the core halfway through a word. A design that gives host strobes priority in a collision would corrupt a freshly loaded word or leave the sequence on the low half. Random mixes of mode changes, simultaneous read and write, and loads in the middle of a sequence are checked against a bench reference model, so a design that latches read data after the update, or that moves the pending-half flag in narrow mode, also shows up.

// File: rtl/hdr_pkg.sv
package hdr_pkg;

    localparam int BYTE_W = 8;
    localparam int DR_W   = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [DR_W-1:0]   word_t;

    // One decoded action per clock; the core load outranks every host action.
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_RD_HI,
        OP_RD_LO,
        OP_RD_NARROW,
        OP_WR_HI,
        OP_WR_LO,
        OP_WR_NARROW,
        OP_CORE_LOAD
    } op_e;

    typedef struct packed {
        logic req;   // transfer requested by the core
        logic half;  // 1 = low byte is next in wide mode
    } stat_t;

    function automatic byte_t pick_byte(word_t w, logic wide, logic half);
        return (wide && !half) ? w[DR_W-1:BYTE_W] : w[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/hdr_op_decode.sv
module hdr_op_decode
    import hdr_pkg::*;
(
    input  logic wide_mode,
    input  logic half,
    input  logic host_rd,
    input  logic host_wr,
    input  logic core_load,
    output op_e  op
);
    always_comb begin
        if (core_load) begin
            op = OP_CORE_LOAD;
        end else if (host_wr) begin
            if (!wide_mode)  op = OP_WR_NARROW;
            else if (!half)  op = OP_WR_HI;
            else             op = OP_WR_LO;
        end else if (host_rd) begin
            if (!wide_mode)  op = OP_RD_NARROW;
            else if (!half)  op = OP_RD_HI;
            else             op = OP_RD_LO;
        end else begin
            op = OP_IDLE;
        end
    end
endmodule

// File: rtl/hdr_status.sv
module hdr_status
    import hdr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_e   op,
    output stat_t stat
);
    stat_t nxt;

    always_comb begin
        nxt = stat;
        unique case (op)
            OP_CORE_LOAD: begin nxt.req = 1'b1; nxt.half = 1'b0; end
            OP_RD_HI,
            OP_WR_HI:     nxt.half = 1'b1;
            OP_RD_LO,
            OP_WR_LO:     begin nxt.req = 1'b0; nxt.half = 1'b0; end
            OP_RD_NARROW,
            OP_WR_NARROW: nxt.req = 1'b0;
            default:      nxt = stat;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= nxt;
    end
endmodule

// File: rtl/hdr_data_reg.sv
module hdr_data_reg
    import hdr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_e   op,
    input  byte_t wbyte,
    input  word_t core_word,
    output word_t dr
);
    word_t nxt;

    always_comb begin
        nxt = dr;
        unique case (op)
            OP_CORE_LOAD: nxt = core_word;
            OP_WR_HI:     nxt = {wbyte, dr[BYTE_W-1:0]};
            OP_WR_LO:     nxt = {dr[DR_W-1:BYTE_W], wbyte};
            OP_WR_NARROW: nxt = {{BYTE_W{1'b0}}, wbyte};
            default:      nxt = dr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) dr <= '0;
        else     dr <= nxt;
    end
endmodule

// File: rtl/host_dr_port.sv
module host_dr_port
    import hdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wide_mode,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              core_load,
    input  logic [DR_W-1:0]   core_data,
    output logic [DR_W-1:0]   dr_q,
    output logic              req_pending,
    output logic              half_sel
);
    op_e   op;
    stat_t stat;
    word_t dr;

    hdr_op_decode u_dec (
        .wide_mode (wide_mode),
        .half      (stat.half),
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .core_load (core_load),
        .op        (op)
    );

    hdr_status u_stat (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .stat (stat)
    );

    hdr_data_reg u_dr (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .wbyte     (host_wdata),
        .core_word (core_data),
        .dr        (dr)
    );

    assign host_rdata  = pick_byte(dr, wide_mode, stat.half);
    assign dr_q        = dr;
    assign req_pending = stat.req;
    assign half_sel    = stat.half;
endmodule

// File: rtl/host_dr_port_chk.sv
module host_dr_port_chk
    import hdr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wide_mode,
    input logic              host_rd,
    input logic              host_wr,
    input logic [BYTE_W-1:0] host_wdata,
    input logic [BYTE_W-1:0] host_rdata,
    input logic              core_load,
    input logic [DR_W-1:0]   core_data,
    input logic [DR_W-1:0]   dr_q,
    input logic              req_pending,
    input logic              half_sel
);
    assert_core_load_R2: assert property (@(posedge clk) disable iff (rst)
        core_load |=> (req_pending && !half_sel && dr_q == $past(core_data)));

    assert_rd_hi_R4: assert property (@(posedge clk) disable iff (rst)
        (!core_load && host_rd && !host_wr && wide_mode && !half_sel)
        |=> (half_sel && $stable(dr_q) && req_pending == $past(req_pending)));

    assert_rd_lo_R5: assert property (@(posedge clk) disable iff (rst)
        (!core_load && host_rd && !host_wr && wide_mode && half_sel)
        |=> (!half_sel && !req_pending && $stable(dr_q)));

    assert_wr_hi_R6: assert property (@(posedge clk) disable iff (rst)
        (!core_load && host_wr && wide_mode && !half_sel)
        |=> (half_sel && dr_q[DR_W-1:BYTE_W] == $past(host_wdata)
             && dr_q[BYTE_W-1:0] == $past(dr_q[BYTE_W-1:0])));

    assert_wr_lo_R7: assert property (@(posedge clk) disable iff (rst)
        (!core_load && host_wr && wide_mode && half_sel)
        |=> (!half_sel && !req_pending && dr_q[BYTE_W-1:0] == $past(host_wdata)
             && dr_q[DR_W-1:BYTE_W] == $past(dr_q[DR_W-1:BYTE_W])));

    assert_wr_narrow_R9: assert property (@(posedge clk) disable iff (rst)
        (!core_load && host_wr && !wide_mode)
        |=> (!req_pending && dr_q == {{BYTE_W{1'b0}}, $past(host_wdata)}
             && half_sel == $past(half_sel)));

    assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (!core_load && !host_rd && !host_wr)
        |=> ($stable(dr_q) && $stable(req_pending) && $stable(half_sel)));

    assert_rdata_R12: assert property (@(posedge clk) disable iff (rst)
        (wide_mode && !half_sel) |-> host_rdata == dr_q[DR_W-1:BYTE_W]);
endmodule

bind host_dr_port host_dr_port_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wide_mode   (wide_mode),
    .host_rd     (host_rd),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .core_load   (core_load),
    .core_data   (core_data),
    .dr_q        (dr_q),
    .req_pending (req_pending),
    .half_sel    (half_sel)
);

// File: tb/host_dr_port_test.sv
module host_dr_port_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        wide_mode, host_rd, host_wr, core_load;
    logic [7:0]  host_wdata, host_rdata;
    logic [15:0] core_data, dr_q;
    logic        req_pending, half_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] m_dr;
    logic        m_half, m_req;

    always #5 clk = ~clk;

    host_dr_port uut (
        .clk(clk), .rst(rst), .wide_mode(wide_mode),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .core_load(core_load), .core_data(core_data),
        .dr_q(dr_q), .req_pending(req_pending), .half_sel(half_sel)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(logic [15:0] w, logic wide, logic half);
        return (wide && !half) ? w[15:8] : w[7:0];
    endfunction

    // Called just after a falling edge; applies one cycle of stimulus.
    task automatic step(logic w, logic rd, logic wr, logic [7:0] wd, logic ld, logic [15:0] dd);
        string tag;
        wide_mode = w; host_rd = rd; host_wr = wr; host_wdata = wd;
        core_load = ld; core_data = dd;
        #1;
        check("R12", "rdata", host_rdata, exp_byte(m_dr, w, m_half));
        if (ld) begin
            tag = (rd || wr) ? "R3" : "R2";
            m_dr = dd; m_req = 1'b1; m_half = 1'b0;
        end else if (wr) begin
            if (w && !m_half)      begin tag = "R6"; m_dr[15:8] = wd; m_half = 1'b1; end
            else if (w)            begin tag = "R7"; m_dr[7:0] = wd; m_half = 1'b0; m_req = 1'b0; end
            else                   begin tag = "R9"; m_dr = {8'h00, wd}; m_req = 1'b0; end
            if (rd) tag = {tag, "/R10"};
        end else if (rd) begin
            if (w && !m_half)      begin tag = "R4"; m_half = 1'b1; end
            else if (w)            begin tag = "R5"; m_half = 1'b0; m_req = 1'b0; end
            else                   begin tag = "R8"; m_req = 1'b0; end
        end else begin
            tag = "R11";
        end
        @(negedge clk);
        check(tag, "dr", dr_q, m_dr);
        check(tag, "half", half_sel, m_half);
        check(tag, "req", req_pending, m_req);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20101223));
        rst = 1'b1; wide_mode = 1'b1; host_rd = 1'b0; host_wr = 1'b1;
        host_wdata = 8'hFF; core_load = 1'b1; core_data = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0; host_wr = 1'b0; core_load = 1'b0;
        m_dr = '0; m_half = 1'b0; m_req = 1'b0;
        check("R1", "dr", dr_q, 16'h0000);
        check("R1", "half", half_sel, 1'b0);
        check("R1", "req", req_pending, 1'b0);

        // Wide read sequence: high byte first, request flag drops only at the end.
        step(1, 0, 0, 8'h00, 1, 16'hA55A);   // R2
        step(1, 1, 0, 8'h00, 0, 16'h0000);   // R4
        step(1, 0, 0, 8'h00, 0, 16'h0000);   // R11 mid-sequence
        step(1, 1, 0, 8'h00, 0, 16'h0000);   // R5
        // Wide write sequence keeping the other half.
        step(1, 0, 0, 8'h00, 1, 16'h1234);
        step(1, 0, 1, 8'hC3, 0, 16'h0000);   // R6
        step(1, 0, 1, 8'h7E, 0, 16'h0000);   // R7
        // Narrow mode.
        step(0, 0, 0, 8'h00, 1, 16'hBEEF);
        step(0, 1, 0, 8'h00, 0, 16'h0000);   // R8
        step(0, 0, 1, 8'h99, 0, 16'h0000);   // R9 zeroes high byte
        // Narrow access with low half pending leaves the flag alone.
        step(1, 0, 0, 8'h00, 1, 16'h5566);
        step(1, 1, 0, 8'h00, 0, 16'h0000);
        step(0, 1, 0, 8'h00, 0, 16'h0000);   // R8, half stays 1
        // Collisions.
        step(1, 0, 1, 8'h11, 0, 16'h0000);   // wide low write
        step(1, 1, 1, 8'h22, 1, 16'hCAFE);   // R3
        step(1, 1, 1, 8'h33, 0, 16'h0000);   // R10 high write
        step(1, 1, 0, 8'h00, 1, 16'hF00D);   // R3 mid-sequence reload
        step(1, 1, 1, 8'h44, 0, 16'h0000);   // R10
        step(1, 1, 1, 8'h55, 0, 16'h0000);   // R10 finishes word

        for (int i = 0; i < 4000; i++) begin
            logic ld;
            ld = (($urandom % 8) == 0);
            step(($urandom % 4) != 0, $urandom % 2, ($urandom % 3) == 0,
                 8'($urandom), ld, 16'($urandom));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule